// File: doc/BRIEF.md
# Rotary Knob Quadrature Accumulator

This block turns the two mechanical contacts of a rotary knob into a signed count of steps taken since the host last looked. The contacts arrive asynchronously, are brought into the clock domain through a flop chain, and are decoded as a four-state Gray code. Each legal move one place along the code adds or subtracts one from an internal two's complement register. A move that jumps two places at once, so that both contacts appear to switch together, has no known direction and is ignored.

The host polls on a slow period, typically every few milliseconds. In any clock cycle it may raise the read strobe: during that cycle the count output carries the value that has built up, and at the next edge the register restarts from zero. If a decoded step lands in the same cycle as the read, that step is placed in the fresh register and is not lost. The register saturates at its most positive and most negative values instead of wrapping, so a long spin between polls never reports the wrong sign.

Top module: `knob_step_accum`

## Requirements
- R1: A synchronous reset, active high, sets the count to 0 and sets the stored reference contact state to (A,B) = 00.
- R2: Each contact input passes through a two-flop synchroniser. A contact change set up before a rising edge first shows on the count after the third rising edge, and not after the second.
- R3: The forward order of contact states (A,B) is 00, 01, 11, 10, then back to 00. Each move one place forward adds 1 to the count.
- R4: Each move one place in the reverse order (00, 10, 11, 01, 00) subtracts 1 from the count.
- R5: A change in which both contacts differ from the reference state leaves the count unchanged. The new state then becomes the reference, so the next single-place move from it counts normally.
- R6: The count is 8-bit two's complement. Forward steps at +127 leave it at +127, and a reverse step from there gives +126.
- R7: Reverse steps at -128 leave the count at -128, and a forward step from there gives -127.
- R8: While the read strobe is high, count_o carries the accumulated count. At the rising edge that samples the strobe, the count restarts from zero.
- R9: If a step is decoded in the same cycle as a read, count_o shows the value from before the step, and after the edge the count is +1 or -1 according to the step's direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| knob_a_i | input | 1 | Knob contact A, asynchronous |
| knob_b_i | input | 1 | Knob contact B, asynchronous |
| rd_clr_i | input | 1 | Read strobe: take count_o this cycle and clear it at the edge |
| count_o | output | 8 | Signed step count since the last read, two's complement |

## Verification
A contact change is due on count_o three rising edges after the bench drives it. There are two synchroniser flops and then the accumulator register, and the reference state register does not add a cycle. Each task drives the contacts on a falling edge, counts the rising edges, and samples on the next falling edge. The latency test also samples after only two edges to show that the step has not arrived early. Read results have two due points: the value is read during the strobe cycle, before its edge, and the clear or one-step reload is read on the falling edge after it. The read-with-step case raises the strobe so that its edge is exactly the third edge after the contact change.

// File: rtl/knob_pkg.sv
package knob_pkg;

   typedef enum logic [1:0] {
      MOVE_NONE = 2'd0,
      MOVE_FWD  = 2'd1,
      MOVE_REV  = 2'd2,
      MOVE_BAD  = 2'd3
   } move_e;

   // Forward successor in the contact Gray cycle, bits ordered {A,B}
   function automatic logic [1:0] gray_succ(input logic [1:0] s);
      logic [1:0] r;
      case (s)
         2'b00:   r = 2'b01;
         2'b01:   r = 2'b11;
         2'b11:   r = 2'b10;
         default: r = 2'b00;
      endcase
      return r;
   endfunction

   function automatic move_e classify(input logic [1:0] ref_s, input logic [1:0] now_s);
      move_e m;
      if (ref_s == now_s)                 m = MOVE_NONE;
      else if (gray_succ(ref_s) == now_s) m = MOVE_FWD;
      else if (gray_succ(now_s) == ref_s) m = MOVE_REV;
      else                                m = MOVE_BAD;
      return m;
   endfunction

endpackage

// File: rtl/knob_sync.sv
module knob_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int LAST = STAGES - 1;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk_i) begin
         if (rst_i) chain_q <= '0;
         else       chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end

      assign sync_o[b] = chain_q[LAST];
   end

endmodule

// File: rtl/knob_quad_decode.sv
module knob_quad_decode
   import knob_pkg::*;
#(
   parameter bit REVERSE = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [1:0] ab_i,
   output move_e      move_o
);

   logic [1:0] ref_q;
   move_e      raw;

   always_ff @(posedge clk_i) begin
      if (rst_i) ref_q <= 2'b00;
      else       ref_q <= ab_i;
   end

   assign raw = classify(ref_q, ab_i);

   if (REVERSE) begin : g_swap
      always_comb begin
         case (raw)
            MOVE_FWD: move_o = MOVE_REV;
            MOVE_REV: move_o = MOVE_FWD;
            default:  move_o = raw;
         endcase
      end
   end else begin : g_direct
      assign move_o = raw;
   end

endmodule

// File: rtl/knob_delta_acc.sv
module knob_delta_acc
   import knob_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  move_e                   move_i,
   input  logic                    rd_clr_i,
   output logic signed [CNT_W-1:0] count_o
);

   localparam logic signed [CNT_W-1:0] TOP_V = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic signed [CNT_W-1:0] BOT_V = {1'b1, {(CNT_W-1){1'b0}}};

   logic signed [CNT_W-1:0] acc_q;
   logic signed [CNT_W-1:0] base;
   logic signed [CNT_W-1:0] acc_d;

   always_comb begin
      base = rd_clr_i ? '0 : acc_q;
      acc_d = base;
      if (move_i == MOVE_FWD && base != TOP_V)      acc_d = base + 1'b1;
      else if (move_i == MOVE_REV && base != BOT_V) acc_d = base - 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) acc_q <= '0;
      else       acc_q <= acc_d;
   end

   assign count_o = acc_q;

endmodule

// File: rtl/knob_step_accum.sv
module knob_step_accum
   import knob_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit REVERSE     = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             knob_a_i,
   input  logic             knob_b_i,
   input  logic             rd_clr_i,
   output logic [CNT_W-1:0] count_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("knob_step_accum: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("knob_step_accum: SYNC_STAGES must be at least 2");
   end

   logic [1:0]              ab_sync;
   move_e                   move;
   logic signed [CNT_W-1:0] cnt;

   knob_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i ({knob_a_i, knob_b_i}),
      .sync_o  (ab_sync)
   );

   knob_quad_decode #(.REVERSE(REVERSE)) dec_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .ab_i   (ab_sync),
      .move_o (move)
   );

   knob_delta_acc #(.CNT_W(CNT_W)) acc_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .move_i   (move),
      .rd_clr_i (rd_clr_i),
      .count_o  (cnt)
   );

   assign count_o = cnt;

endmodule

module knob_step_accum_chk
   import knob_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             rd_clr_i,
   input logic [CNT_W-1:0] count_o,
   input move_e            move
);

   localparam logic signed [CNT_W-1:0] TOP_V = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic signed [CNT_W-1:0] BOT_V = {1'b1, {(CNT_W-1){1'b0}}};

   logic live_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) live_q <= 1'b0;
      else       live_q <= 1'b1;
   end

   // R1
   reset_zero_chk: assert property (@(posedge clk_i) rst_i |=> count_o == '0);

   // R5
   bad_move_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (move == MOVE_BAD && !rd_clr_i) |=> $stable(count_o));

   // R6
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (live_q && !$past(rd_clr_i) && $past(count_o) == TOP_V) |-> count_o != BOT_V);

   // R7
   no_underflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (live_q && !$past(rd_clr_i) && $past(count_o) == BOT_V) |-> count_o != TOP_V);

   // R8
   read_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_clr_i && move == MOVE_NONE) |=> count_o == '0);

   // R9
   read_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_clr_i && (move == MOVE_FWD || move == MOVE_REV)) |=> $countones(count_o) == 1 || count_o == '1);

endmodule

bind knob_step_accum knob_step_accum_chk #(.CNT_W(CNT_W)) chk_i (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .rd_clr_i (rd_clr_i),
   .count_o  (count_o),
   .move     (move)
);

// File: tb/knob_step_accum_tb_top.sv
module knob_step_accum_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       ka;
   logic       kb;
   logic       rd;
   logic [7:0] cnt;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   int pos   = 0;

   always #4 clk = ~clk;

   knob_step_accum dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .knob_a_i (ka),
      .knob_b_i (kb),
      .rd_clr_i (rd),
      .count_o  (cnt)
   );

   function automatic logic [1:0] ab_of(input int p);
      logic [1:0] r;
      case (p & 3)
         0:       r = 2'b00;
         1:       r = 2'b01;
         2:       r = 2'b11;
         default: r = 2'b10;
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cval();
      return int'($signed(cnt));
   endfunction

   task automatic drive_pos(input int p);
      @(negedge clk);
      pos = p;
      {ka, kb} = ab_of(p);
   endtask

   // move one place and wait until it is due on count_o
   task automatic step(input int dir);
      drive_pos(pos + dir + 4);
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk);
      rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; rd = 1'b0; ka = 1'b0; kb = 1'b0; pos = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 count after reset", cval(), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 no step from idle contacts", cval(), 0);
   endtask

   task automatic t_latency();
      drive_pos(pos + 1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 not due after two edges", cval(), 0);
      @(posedge clk);
      @(negedge clk);
      check("R2 due after third edge", cval(), 1);
      do_read();
   endtask

   task automatic t_forward();
      for (int i = 0; i < 8; i++) step(1);
      check("R3 eight forward steps", cval(), 8);
      @(negedge clk);
      rd = 1'b1;
      #1;
      check("R8 value during read", cval(), 8);
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
      check("R8 cleared after read", cval(), 0);
   endtask

   task automatic t_reverse();
      for (int i = 0; i < 6; i++) step(-1);
      check("R4 six reverse steps", cval(), -6);
      step(1);
      check("R4 direction change nets out", cval(), -5);
      do_read();
      check("R8 cleared after negative read", cval(), 0);
   endtask

   task automatic t_invalid();
      drive_pos(pos + 2);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R5 double change ignored", cval(), 0);
      step(1);
      check("R5 new reference counts next step", cval(), 1);
      do_read();
   endtask

   task automatic t_sat_pos();
      for (int i = 0; i < 140; i++) step(1);
      check("R6 held at +127", cval(), 127);
      step(-1);
      check("R6 reverse from max", cval(), 126);
      do_read();
   endtask

   task automatic t_sat_neg();
      for (int i = 0; i < 140; i++) step(-1);
      check("R7 held at -128", cval(), -128);
      step(1);
      check("R7 forward from min", cval(), -127);
      do_read();
   endtask

   task automatic t_read_step();
      step(1);
      step(1);
      step(1);
      drive_pos(pos + 1);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rd = 1'b1;
      #1;
      check("R9 old value shown in read cycle", cval(), 3);
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
      check("R9 forward step reloaded", cval(), 1);
      do_read();
      step(-1);
      step(-1);
      drive_pos(pos - 1 + 4);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rd = 1'b1;
      #1;
      check("R9 old negative value shown", cval(), -2);
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
      check("R9 reverse step reloaded", cval(), -1);
      do_read();
   endtask

   initial begin
      t_reset();
      t_latency();
      t_forward();
      t_reverse();
      t_invalid();
      t_sat_pos();
      t_sat_neg();
      t_read_step();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule